// File: doc/BRIEF.md
# Bus Slave Select and Wait-State Responder

This block sits on the slave side of a multi-master parallel bus. It compares the bus address and the memory/IO qualifier with a window fixed by parameters. While the address is in the window it reports at once, through combinational logic, that it is selected and which data widths its port accepts. A master may place the next cycle's address on the bus before the current cycle ends, so these feedback lines must follow the address with no latching.

For the transfer itself, the block takes a snapshot of its select decode and of the transfer direction. It does this at the first clock on which either the address-latch strobe or the command strobe is seen low, and holds the snapshot until both status and command have gone inactive. It can stretch the cycle by pulling its ready output low. Ready is never pulled low before the address-latch strobe has been seen. The stretch has three forms, chosen by a parameter: no stretch, a fixed number of clocks counted while command is active, or a hold until a local completion input fires. A cycle that ends without a command releases ready at once. On the local side the block gives a read enable while a selected read command is active, a read-drive enable for the data bus, and a one-cycle write strobe with the data captured as the command ends.

All bus inputs are taken to be synchronous to `clk`.

Top module: `bus_slave_resp`

## Requirements
- R1: `sel_fb_n` is low in the same cycle, combinationally, exactly when `(addr & ADDR_MASK) == (ADDR_BASE & ADDR_MASK)` and `mem_io == MEM_MATCH`. It follows address changes even while a cycle is in progress.
- R2: With PORT_W = 32, both `sz16_n` and `sz32_n` are low whenever `sel_fb_n` is low. With PORT_W = 16, only `sz16_n` goes low. With PORT_W = 8, neither goes low. While the block is not selected, both are high.
- R3: The select decode and the direction (write when `st_wr_n` is low) are captured on the first rising clock edge at which `addr_lat_n` or `xfer_n` is low. Later address changes do not alter that capture. It is cleared at an edge where `st_wr_n`, `st_rd_n` and `xfer_n` are all high.
- R4: `rdy` is high out of reset and stays high in every cycle until an edge has sampled `addr_lat_n` low with a hit and active status. In MODE EXT_NONE, `rdy` is always high.
- R5: In MODE EXT_SYNC, `rdy` goes low right after the edge that samples `addr_lat_n` low with a hit and active status. It returns high right after the WAIT_CLKS-th edge that samples `xfer_n` low. Status going inactive before that point has no effect.
- R6: In MODE EXT_ASYNC, `rdy` goes low at the same point as in R5 and returns high right after the first edge that samples `done_i` high. Status has no effect on this release.
- R7: If status and `xfer_n` are both sampled inactive while `rdy` is low (an aborted or finished cycle), `rdy` is high right after that edge.
- R8: At the edge where `xfer_n` is sampled high after being low in a captured write, `loc_wr_en` goes high for exactly one cycle and `wdata_q` takes the `wdata` value sampled at that edge. A read or an unselected cycle gives no strobe and leaves `wdata_q` unchanged.
- R9: `loc_rd_en` is high while a captured selected read has `xfer_n` low. `rd_drive` is high while a captured selected read has status or command active. Both drop once the capture is cleared.
- R10: While reset is applied and right after it, `rdy` is 1 and `loc_wr_en`, `loc_rd_en` and `rd_drive` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | AW | Bus address |
| mem_io | input | 1 | 1 = memory space, 0 = IO space |
| st_wr_n | input | 1 | Write status, active low |
| st_rd_n | input | 1 | Read status, active low |
| addr_lat_n | input | 1 | Address-latch strobe, active low |
| xfer_n | input | 1 | Command strobe, active low |
| wdata | input | DW | Write data on the bus |
| done_i | input | 1 | Local completion for the asynchronous stretch |
| sel_fb_n | output | 1 | Select feedback, unlatched, active low |
| sz16_n | output | 1 | 16-bit port indication, active low |
| sz32_n | output | 1 | 32-bit port indication, active low |
| rdy | output | 1 | Ready; low adds wait states |
| rd_drive | output | 1 | Enable for driving read data on the bus |
| loc_rd_en | output | 1 | Local read enable |
| loc_wr_en | output | 1 | One-cycle local write strobe |
| wdata_q | output | DW | Captured write data |

## Verification
If the captured select or direction is wrong, the error shows within one clock of the command edge. `loc_rd_en` and `rd_drive` take the wrong level during the command, and after the command rises the write strobe either appears when it should not or fails to appear. If the wait-state state or its counter is wrong, `rdy` is low on a cycle with no address strobe, is released one edge early or late against the count, or is never released after an abort, so every check is made one edge after the cause. The sweep covers every address in both spaces for the unlatched decode, and the transfer runs cover reads and writes, hits and misses, strobe-latched and command-latched capture, different completion times and aborts.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {EXT_NONE, EXT_SYNC, EXT_ASYNC} ext_mode_e;
  typedef enum logic [1:0] {RS_IDLE, RS_HOLD, RS_DONE} rdy_st_e;
endpackage

// File: rtl/bsr_decode.sv
module bsr_decode #(
  parameter int          AW        = 8,
  parameter logic [AW-1:0] ADDR_BASE = '0,
  parameter logic [AW-1:0] ADDR_MASK = '0,
  parameter logic        MEM_MATCH = 1'b1,
  parameter int          PORT_W    = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          mem_io,
  output logic          hit,
  output logic          sel_fb_n,
  output logic          sz16_n,
  output logic          sz32_n
);
  localparam logic [AW-1:0] MATCH = ADDR_BASE & ADDR_MASK;

  // unlatched decode: the next cycle's address may already be on the bus
  assign hit      = ((addr & ADDR_MASK) == MATCH) && (mem_io == MEM_MATCH);
  assign sel_fb_n = ~hit;

  generate
    if (PORT_W >= 32) begin : g_w32
      assign sz16_n = ~hit;
      assign sz32_n = ~hit;
    end else if (PORT_W >= 16) begin : g_w16
      assign sz16_n = ~hit;
      assign sz32_n = 1'b1;
    end else begin : g_w8
      assign sz16_n = 1'b1;
      assign sz32_n = 1'b1;
    end
  endgenerate

  always_comb begin
    if (sel_fb_n === 1'b1) begin
      AST_SIZE_NEEDS_SEL: assert (sz16_n && sz32_n); // R2
    end
  end
endmodule

// File: rtl/bsr_sel_latch.sv
module bsr_sel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic addr_lat_n,
  input  logic xfer_n,
  input  logic st_wr_n,
  input  logic st_rd_n,
  output logic sel_q,
  output logic wr_q
);
  logic lat_q, lat_d, sel_d, wr_d;
  logic cyc_end, take_now;

  assign cyc_end  = st_wr_n & st_rd_n & xfer_n;
  assign take_now = ~lat_q & (~addr_lat_n | ~xfer_n);

  always_comb begin
    lat_d = lat_q;
    sel_d = sel_q;
    wr_d  = wr_q;
    if (cyc_end) begin
      lat_d = 1'b0;
      sel_d = 1'b0;
      wr_d  = 1'b0;
    end else if (take_now) begin
      lat_d = 1'b1;
      sel_d = hit;
      wr_d  = ~st_wr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      lat_q <= lat_d;
      sel_q <= sel_d;
      wr_q  <= wr_d;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !cyc_end) |=> ($stable(sel_q) && $stable(wr_q))); // R3
  AST_SEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !sel_q); // R3
endmodule

// File: rtl/bsr_rdy_ctrl.sv
module bsr_rdy_ctrl
  import bsr_pkg::*;
#(
  parameter ext_mode_e MODE      = EXT_SYNC,
  parameter int        WAIT_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic addr_lat_n,
  input  logic xfer_n,
  input  logic st_active,
  input  logic done_i,
  output logic rdy
);
  localparam int CW = $clog2(WAIT_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CLKS - 1);

  rdy_st_e        st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           idle_bus;

  assign idle_bus = ~st_active & xfer_n;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      RS_IDLE: begin
        cnt_d = '0;
        if (MODE != EXT_NONE && !addr_lat_n && hit && st_active) st_d = RS_HOLD;
      end
      RS_HOLD: begin
        if (idle_bus) begin
          st_d = RS_IDLE;
        end else if (MODE == EXT_ASYNC) begin
          if (done_i) st_d = RS_DONE;
        end else if (!xfer_n) begin
          if (cnt_q == LAST) st_d = RS_DONE;
          else               cnt_d = cnt_q + 1'b1;
        end
      end
      RS_DONE: begin
        if (idle_bus) st_d = RS_IDLE;
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign rdy = (st_q != RS_HOLD);

  AST_NO_EARLY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(!addr_lat_n)); // R4
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && idle_bus) |=> rdy); // R7
  AST_ASYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == EXT_ASYNC && !rdy && done_i) |=> rdy); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(WAIT_CLKS)); // R5
endmodule

// File: rtl/bus_slave_resp.sv
module bus_slave_resp
  import bsr_pkg::*;
#(
  parameter int            AW        = 8,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] ADDR_BASE = 8'h40,
  parameter logic [AW-1:0] ADDR_MASK = 8'hF0,
  parameter logic          MEM_MATCH = 1'b1,
  parameter int            PORT_W    = 32,
  parameter ext_mode_e     MODE      = EXT_SYNC,
  parameter int            WAIT_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          mem_io,
  input  logic          st_wr_n,
  input  logic          st_rd_n,
  input  logic          addr_lat_n,
  input  logic          xfer_n,
  input  logic [DW-1:0] wdata,
  input  logic          done_i,
  output logic          sel_fb_n,
  output logic          sz16_n,
  output logic          sz32_n,
  output logic          rdy,
  output logic          rd_drive,
  output logic          loc_rd_en,
  output logic          loc_wr_en,
  output logic [DW-1:0] wdata_q
);
  logic          rs_meta_q, rst_n_s;
  logic          hit, sel_q, wr_q, st_active;
  logic          xfer_d_q, wr_fire;
  logic [DW-1:0] wdata_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rst_n_s   <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rst_n_s   <= rs_meta_q;
    end
  end

  assign st_active = ~st_wr_n | ~st_rd_n;

  bsr_decode #(
    .AW(AW), .ADDR_BASE(ADDR_BASE), .ADDR_MASK(ADDR_MASK),
    .MEM_MATCH(MEM_MATCH), .PORT_W(PORT_W)
  ) u_dec (
    .addr(addr), .mem_io(mem_io), .hit(hit),
    .sel_fb_n(sel_fb_n), .sz16_n(sz16_n), .sz32_n(sz32_n)
  );

  bsr_sel_latch u_sel (
    .clk(clk), .rst_n(rst_n_s), .hit(hit), .addr_lat_n(addr_lat_n),
    .xfer_n(xfer_n), .st_wr_n(st_wr_n), .st_rd_n(st_rd_n),
    .sel_q(sel_q), .wr_q(wr_q)
  );

  bsr_rdy_ctrl #(.MODE(MODE), .WAIT_CLKS(WAIT_CLKS)) u_rdy (
    .clk(clk), .rst_n(rst_n_s), .hit(hit), .addr_lat_n(addr_lat_n),
    .xfer_n(xfer_n), .st_active(st_active), .done_i(done_i), .rdy(rdy)
  );

  assign loc_rd_en = sel_q & ~wr_q & ~xfer_n;
  assign rd_drive  = sel_q & ~wr_q & (st_active | ~xfer_n);
  assign wr_fire   = sel_q & wr_q & xfer_n & ~xfer_d_q;
  assign wdata_d   = wr_fire ? wdata : wdata_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      xfer_d_q  <= 1'b1;
      loc_wr_en <= 1'b0;
      wdata_q   <= '0;
    end else begin
      xfer_d_q  <= xfer_n;
      loc_wr_en <= wr_fire;
      wdata_q   <= wdata_d;
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    loc_wr_en |=> !loc_wr_en); // R8
  AST_WR_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(loc_wr_en) |-> $past(xfer_n)); // R8
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(loc_rd_en && loc_wr_en)); // R9
endmodule

// File: tb/sim_bus_slave_resp.sv
`timescale 1ns/1ps
module sim_bus_slave_resp;
  import bsr_pkg::*;

  localparam int WAITS = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        mem_io, st_wr_n, st_rd_n, addr_lat_n, xfer_n, done_i;
  logic [15:0] wdata;

  logic        fb0, s160, s320, rdy0, drv0, rde0, wre0;
  logic        fb1, s161, s321, rdy1, drv1, rde1, wre1;
  logic        fb2, s162, s322, rdy2, drv2, rde2, wre2;
  logic [15:0] wq0, wq1, wq2;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bus_slave_resp #(.PORT_W(32), .MODE(EXT_SYNC), .WAIT_CLKS(WAITS)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_io(mem_io), .st_wr_n(st_wr_n),
    .st_rd_n(st_rd_n), .addr_lat_n(addr_lat_n), .xfer_n(xfer_n), .wdata(wdata),
    .done_i(done_i), .sel_fb_n(fb0), .sz16_n(s160), .sz32_n(s320), .rdy(rdy0),
    .rd_drive(drv0), .loc_rd_en(rde0), .loc_wr_en(wre0), .wdata_q(wq0));

  bus_slave_resp #(.PORT_W(16), .MODE(EXT_NONE), .WAIT_CLKS(WAITS)) u1 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_io(mem_io), .st_wr_n(st_wr_n),
    .st_rd_n(st_rd_n), .addr_lat_n(addr_lat_n), .xfer_n(xfer_n), .wdata(wdata),
    .done_i(done_i), .sel_fb_n(fb1), .sz16_n(s161), .sz32_n(s321), .rdy(rdy1),
    .rd_drive(drv1), .loc_rd_en(rde1), .loc_wr_en(wre1), .wdata_q(wq1));

  bus_slave_resp #(.PORT_W(8), .MODE(EXT_ASYNC), .WAIT_CLKS(WAITS)) u2 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_io(mem_io), .st_wr_n(st_wr_n),
    .st_rd_n(st_rd_n), .addr_lat_n(addr_lat_n), .xfer_n(xfer_n), .wdata(wdata),
    .done_i(done_i), .sel_fb_n(fb2), .sz16_n(s162), .sz32_n(s322), .rdy(rdy2),
    .rd_drive(drv2), .loc_rd_en(rde2), .loc_wr_en(wre2), .wdata_q(wq2));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_idle();
    st_wr_n = 1'b1; st_rd_n = 1'b1; addr_lat_n = 1'b1; xfer_n = 1'b1; done_i = 1'b0;
  endtask

  // one transfer; done_at: command-low edge index at which done_i is sampled high
  task automatic xfer(input bit wr, input bit hit, input bit use_adl,
                      input int done_at, input bit abort, input logic [15:0] d);
    logic [15:0] old_q;
    bit          ext;
    old_q = wq0;
    ext   = hit && use_adl;
    @(negedge clk);
    addr = hit ? 8'h4A : 8'h5A; mem_io = 1'b1;
    st_wr_n = ~wr; st_rd_n = wr;
    #1 chk(rdy0 && rdy2, "R4 ready before strobe", {rdy0, rdy2}, 2'b11);
    @(negedge clk);
    addr_lat_n = ~use_adl;
    @(posedge clk); @(negedge clk); #1;
    chk(rdy0 == !ext, "R5 sync hold after strobe", rdy0, !ext);
    chk(rdy2 == !ext, "R6 async hold after strobe", rdy2, !ext);
    chk(rdy1 == 1'b1, "R4 default mode never waits", rdy1, 1);
    if (abort) begin
      st_wr_n = 1'b1; st_rd_n = 1'b1; addr_lat_n = 1'b1;
      @(posedge clk); @(negedge clk); #1;
      chk(rdy0 && rdy2, "R7 abort releases ready", {rdy0, rdy2}, 2'b11);
      chk(!drv0 && !rde0, "R9 abort drops drive", {drv0, rde0}, 0);
      @(posedge clk); @(negedge clk); #1;
      chk(!wre0 && wq0 == old_q, "R8 abort gives no write", wq0, old_q);
      return;
    end
    addr_lat_n = 1'b1; xfer_n = 1'b0; wdata = d; done_i = (done_at == 0);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk); #1;
      chk(rdy0 == (!ext || (k + 1 >= WAITS)), "R5 sync count release", rdy0,
          (!ext || (k + 1 >= WAITS)));
      chk(rdy2 == (!ext || (done_at <= k)), "R6 async done release", rdy2,
          (!ext || (done_at <= k)));
      if (k == 0) begin
        chk(rde0 == (!wr && hit), "R9 read enable", rde0, (!wr && hit));
        chk(drv0 == (!wr && hit), "R9 read drive", drv0, (!wr && hit));
        addr = 8'hC3;
      end
      if (k == 1) begin
        chk(fb0 == 1'b1, "R1 feedback follows address", fb0, 1);
        chk(rde0 == (!wr && hit), "R3 capture held after address change", rde0,
            (!wr && hit));
        st_wr_n = 1'b1; st_rd_n = 1'b1;
      end
      if (k == 3)
        chk(drv0 == (!wr && hit), "R9 drive held while command active", drv0,
            (!wr && hit));
      done_i = (k + 1 == done_at);
    end
    xfer_n = 1'b1; done_i = 1'b0;
    @(posedge clk); @(negedge clk); #1;
    chk(wre0 == (wr && hit), "R8 write strobe", wre0, (wr && hit));
    chk(wq0 == ((wr && hit) ? d : old_q), "R8 captured data", wq0,
        (wr && hit) ? d : old_q);
    chk(!drv0 && !rde0, "R9 drive off after cycle", {drv0, rde0}, 0);
    chk(rdy0 && rdy2, "R7 ready high at cycle end", {rdy0, rdy2}, 2'b11);
    wdata = ~d;
    @(posedge clk); @(negedge clk); #1;
    chk(!wre0 && wq0 == ((wr && hit) ? d : old_q), "R8 single strobe", wq0,
        (wr && hit) ? d : old_q);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; mem_io = 1'b0; wdata = '0;
    bus_idle();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(rdy0 && rdy1 && rdy2, "R10 ready in reset", {rdy0, rdy1, rdy2}, 3'b111);
    chk(!wre0 && !rde0 && !drv0, "R10 enables in reset", {wre0, rde0, drv0}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(rdy0 && rdy2 && !wre0 && !drv0, "R10 state after reset",
        {rdy0, rdy2, wre0, drv0}, 4'b1100);

    // R1 R2 sweep of the unlatched decode
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        bit h;
        addr = 8'(a); mem_io = m[0];
        h = ((a & 8'hF0) == 8'h40) && (m == 1);
        #1;
        chk(fb0 == !h && fb1 == !h && fb2 == !h, "R1 select feedback",
            {fb0, fb1, fb2}, {3{!h}});
        chk(s160 == !h && s320 == !h && s161 == !h && s321 && s162 && s322,
            "R2 size lines", {s160, s320, s161, s321, s162, s322},
            {!h, !h, !h, 1'b1, 1'b1, 1'b1});
      end
    end

    // transfers: wr, hit, adl, done_at, abort, data
    for (int w = 0; w < 2; w++) begin
      for (int h = 0; h < 2; h++) begin
        for (int l = 0; l < 2; l++) begin
          for (int dn = 0; dn < 6; dn += 2)
            xfer(w[0], h[0], l[0], dn, 1'b0, 16'(16'hA500 + w * 64 + h * 16 + l * 4 + dn));
        end
      end
    end
    xfer(1'b1, 1'b1, 1'b1, 5, 1'b1, 16'h1234);
    xfer(1'b0, 1'b1, 1'b1, 5, 1'b1, 16'h4321);
    xfer(1'b1, 1'b1, 1'b1, 1, 1'b0, 16'hBEEF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule